// File: doc/BRIEF.md
# Bufferless Five-Port Mesh Router

This block sits at one node of a two-dimensional processor grid. It has five channels, one toward each of its four neighbours (North, East, South, West) and one toward the processor attached to the node (Local). Every channel carries a packet made of a pixel value, a destination coordinate pair (x, y) and a small frame tag that tells the receiver which input image the pixel belongs to. The router decides, for every incoming packet, which outgoing channel it should leave on, and delivers it there one clock cycle later.

Routing is dimension-ordered. A packet first moves east or west until its x coordinate equals the node's own x. It then moves north or south until y matches. When both match, it is handed to the local processor. The node's own coordinates are parameters of the block. Each input channel has a steering stage that turns its destination into a single requested output. Each output channel has a fixed-priority selector that picks one of the requesting inputs.

The router holds no packet storage and applies no back-pressure, because the traffic it serves is expected to be free of collisions. When two or more inputs want the same output in the same cycle, only the highest-priority one is passed on. The others are discarded, and a conflict flag is raised for that cycle so that the surrounding system can detect the loss.

Top module: `mesh_router`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every output valid bit and the conflict flag are low.
- R2: A valid packet whose destination x is greater than the node's x leaves on the East output (port index 1).
- R3: A valid packet whose destination x is less than the node's x leaves on the West output (port index 3).
- R4: A valid packet whose destination x equals the node's x and whose destination y is greater than the node's y leaves on the North output (port index 0). If the destination y is less than the node's y, the packet leaves on the South output (port index 2).
- R5: A valid packet whose destination x and y both equal the node's coordinates leaves on the Local output (port index 4).
- R6: A packet accepted at a rising edge appears on its output after that edge, and its valid bit stays high for exactly one cycle unless a new packet is routed to the same output.
- R7: The pixel, destination x, destination y and frame tag arrive at the output unchanged.
- R8: When several valid inputs request the same output, only the input with the lowest port index is passed. The order is North(0) > East(1) > South(2) > West(3) > Local(4).
- R9: The conflict flag is high in the same cycle as the outputs of a cycle in which some output had two or more requesters. The losing packets are dropped and never appear on any output.
- R10: An input whose valid bit is low has no effect on any output, whatever its address and data fields hold.
- R11: Packets that request different outputs in the same cycle are all forwarded together, and the conflict flag stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 5 | Per-port input valid, bit index = port index (N,E,S,W,L) |
| in_pix_i | input | 5*PIX_W | Per-port pixel value |
| in_dx_i | input | 5*COORD_W | Per-port destination x |
| in_dy_i | input | 5*COORD_W | Per-port destination y |
| in_frm_i | input | 5*FRM_W | Per-port frame tag |
| out_vld_o | output | 5 | Per-port output valid |
| out_pix_o | output | 5*PIX_W | Per-port forwarded pixel |
| out_dx_o | output | 5*COORD_W | Per-port forwarded destination x |
| out_dy_o | output | 5*COORD_W | Per-port forwarded destination y |
| out_frm_o | output | 5*FRM_W | Per-port forwarded frame tag |
| conflict_o | output | 1 | Output collision occurred in the previous cycle |

## Verification
The embedded properties check several rules on every cycle. Each output carries only addresses that belong to its direction. No valid output appears without a valid input one cycle earlier. No more packets leave than entered. The conflict flag never rises unless at least two inputs were valid. Each selector grants at most one requester and always grants one when it has any. The directed scenarios are needed to show the rest. Only these scenarios show that the correct winner is chosen by priority and that its payload is the one delivered intact. They also show that dropped losers do not reappear in a later cycle, that inputs with valid low leave the outputs untouched, and that disjoint traffic flows in parallel without raising the flag.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

    localparam int NPORT  = 5;
    localparam int P_N    = 0;
    localparam int P_E    = 1;
    localparam int P_S    = 2;
    localparam int P_W    = 3;
    localparam int P_L    = 4;
    localparam int PIDX_W = $clog2(NPORT);

endpackage

// File: rtl/rtr_steer.sv
module rtr_steer
    import rtr_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 2
) (
    input  logic               vld_i,
    input  logic [COORD_W-1:0] dx_i,
    input  logic [COORD_W-1:0] dy_i,
    output logic [NPORT-1:0]   req_o
);

    localparam logic [COORD_W-1:0] HX = MY_X[COORD_W-1:0];
    localparam logic [COORD_W-1:0] HY = MY_Y[COORD_W-1:0];

    always_comb begin
        req_o = '0;
        if (vld_i) begin
            if (dx_i > HX) begin
                req_o[P_E] = 1'b1;
            end else if (dx_i < HX) begin
                req_o[P_W] = 1'b1;
            end else if (dy_i > HY) begin
                req_o[P_N] = 1'b1;
            end else if (dy_i < HY) begin
                req_o[P_S] = 1'b1;
            end else begin
                req_o[P_L] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtr_prio_sel.sv
module rtr_prio_sel #(
    parameter int N = 5
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o,
    output logic         multi_o
);

    logic taken;

    always_comb begin
        gnt_o = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !taken) begin
                gnt_o[i] = 1'b1;
                taken    = 1'b1;
            end
        end
        multi_o = ($countones(req_i) > 1);
    end

    AST_GNT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o)) else $error("grant not one-hot"); // R8

    AST_GNT_WHEN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i != '0) |-> (gnt_o != '0)) else $error("request left ungranted"); // R8

    AST_GNT_IS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((gnt_o & ~req_i) == '0)) else $error("grant without request"); // R10

endmodule

// File: rtl/mesh_router.sv
module mesh_router
    import rtr_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int COORD_W = 3,
    parameter int FRM_W   = 2,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 2
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NPORT-1:0]           in_vld_i,
    input  logic [NPORT*PIX_W-1:0]     in_pix_i,
    input  logic [NPORT*COORD_W-1:0]   in_dx_i,
    input  logic [NPORT*COORD_W-1:0]   in_dy_i,
    input  logic [NPORT*FRM_W-1:0]     in_frm_i,
    output logic [NPORT-1:0]           out_vld_o,
    output logic [NPORT*PIX_W-1:0]     out_pix_o,
    output logic [NPORT*COORD_W-1:0]   out_dx_o,
    output logic [NPORT*COORD_W-1:0]   out_dy_o,
    output logic [NPORT*FRM_W-1:0]     out_frm_o,
    output logic                       conflict_o
);

    localparam logic [COORD_W-1:0] HX = MY_X[COORD_W-1:0];
    localparam logic [COORD_W-1:0] HY = MY_Y[COORD_W-1:0];

    typedef struct packed {
        logic [PIX_W-1:0]   pix;
        logic [COORD_W-1:0] dx;
        logic [COORD_W-1:0] dy;
        logic [FRM_W-1:0]   frm;
    } pkt_t;

    typedef struct packed {
        logic [NPORT-1:0]  vld;
        pkt_t [NPORT-1:0]  pkt;
        logic              conflict;
    } state_t;

    state_t state_d, state_q;

    pkt_t [NPORT-1:0]            in_pkt;
    logic [NPORT-1:0][NPORT-1:0] req_by_in;
    logic [NPORT-1:0][NPORT-1:0] req_by_out;
    logic [NPORT-1:0][NPORT-1:0] gnt_by_out;
    logic [NPORT-1:0]            multi_by_out;

    // Input side: one steering stage per channel
    for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
        assign in_pkt[gi].pix = in_pix_i[gi*PIX_W +: PIX_W];
        assign in_pkt[gi].dx  = in_dx_i[gi*COORD_W +: COORD_W];
        assign in_pkt[gi].dy  = in_dy_i[gi*COORD_W +: COORD_W];
        assign in_pkt[gi].frm = in_frm_i[gi*FRM_W +: FRM_W];

        rtr_steer #(
            .COORD_W (COORD_W),
            .MY_X    (MY_X),
            .MY_Y    (MY_Y)
        ) i_steer (
            .vld_i (in_vld_i[gi]),
            .dx_i  (in_pkt[gi].dx),
            .dy_i  (in_pkt[gi].dy),
            .req_o (req_by_in[gi])
        );

        for (genvar go = 0; go < NPORT; go++) begin : g_xpose
            assign req_by_out[go][gi] = req_by_in[gi][go];
        end
    end

    // Output side: one fixed-priority selector per channel
    for (genvar go = 0; go < NPORT; go++) begin : g_out
        rtr_prio_sel #(
            .N (NPORT)
        ) i_sel (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .req_i   (req_by_out[go]),
            .gnt_o   (gnt_by_out[go]),
            .multi_o (multi_by_out[go])
        );

        assign out_vld_o[go]                      = state_q.vld[go];
        assign out_pix_o[go*PIX_W +: PIX_W]       = state_q.pkt[go].pix;
        assign out_dx_o[go*COORD_W +: COORD_W]    = state_q.pkt[go].dx;
        assign out_dy_o[go*COORD_W +: COORD_W]    = state_q.pkt[go].dy;
        assign out_frm_o[go*FRM_W +: FRM_W]       = state_q.pkt[go].frm;
    end

    assign conflict_o = state_q.conflict;

    always_comb begin
        state_d          = state_q;
        state_d.conflict = |multi_by_out;
        for (int o = 0; o < NPORT; o++) begin
            state_d.vld[o] = |gnt_by_out[o];
            for (int i = 0; i < NPORT; i++) begin
                if (gnt_by_out[o][i]) begin
                    state_d.pkt[o] = in_pkt[i];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    AST_EAST_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_vld_o[P_E] |-> (out_dx_o[P_E*COORD_W +: COORD_W] > HX))
        else $error("east output with wrong x"); // R2

    AST_WEST_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_vld_o[P_W] |-> (out_dx_o[P_W*COORD_W +: COORD_W] < HX))
        else $error("west output with wrong x"); // R3

    AST_NORTH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_vld_o[P_N] |-> (out_dx_o[P_N*COORD_W +: COORD_W] == HX &&
                            out_dy_o[P_N*COORD_W +: COORD_W] > HY))
        else $error("north output with wrong address"); // R4

    AST_SOUTH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_vld_o[P_S] |-> (out_dx_o[P_S*COORD_W +: COORD_W] == HX &&
                            out_dy_o[P_S*COORD_W +: COORD_W] < HY))
        else $error("south output with wrong address"); // R4

    AST_LOCAL_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_vld_o[P_L] |-> (out_dx_o[P_L*COORD_W +: COORD_W] == HX &&
                            out_dy_o[P_L*COORD_W +: COORD_W] == HY))
        else $error("local output with wrong address"); // R5

    AST_IDLE_NO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_vld_i == '0) |=> (out_vld_o == '0))
        else $error("output without input"); // R10

    AST_NO_GAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_vld_i == '0) |=> !conflict_o)
        else $error("conflict without traffic"); // R9

    AST_CONFLICT_NEEDS_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(in_vld_i) < 2) |=> !conflict_o)
        else $error("conflict with fewer than two inputs"); // R9

    AST_NO_OVERCOUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(in_vld_i) < 2) |=> ($countones(out_vld_o) <= 1))
        else $error("more packets out than in"); // R6

endmodule

// File: tb/test_mesh_router.sv
`timescale 1ns/1ps
module test_mesh_router;

    localparam int NP      = 5;
    localparam int PIX_W   = 8;
    localparam int COORD_W = 3;
    localparam int FRM_W   = 2;
    localparam int HX      = 2;
    localparam int HY      = 2;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NP-1:0]            in_vld = '0;
    logic [NP*PIX_W-1:0]      in_pix = '0;
    logic [NP*COORD_W-1:0]    in_dx  = '0;
    logic [NP*COORD_W-1:0]    in_dy  = '0;
    logic [NP*FRM_W-1:0]      in_frm = '0;
    logic [NP-1:0]            out_vld;
    logic [NP*PIX_W-1:0]      out_pix;
    logic [NP*COORD_W-1:0]    out_dx;
    logic [NP*COORD_W-1:0]    out_dy;
    logic [NP*FRM_W-1:0]      out_frm;
    logic                     conflict;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    mesh_router #(
        .PIX_W(PIX_W), .COORD_W(COORD_W), .FRM_W(FRM_W), .MY_X(HX), .MY_Y(HY)
    ) i_mesh_router (
        .clk_i(clk), .rst_ni(rst_n),
        .in_vld_i(in_vld), .in_pix_i(in_pix), .in_dx_i(in_dx),
        .in_dy_i(in_dy), .in_frm_i(in_frm),
        .out_vld_o(out_vld), .out_pix_o(out_pix), .out_dx_o(out_dx),
        .out_dy_o(out_dy), .out_frm_o(out_frm), .conflict_o(conflict)
    );

    function automatic int dir_of(int dx, int dy);
        if (dx > HX) return 1;
        if (dx < HX) return 3;
        if (dy > HY) return 0;
        if (dy < HY) return 2;
        return 4;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put(int p, int pix, int dx, int dy, int frm);
        in_vld[p]                      = 1'b1;
        in_pix[p*PIX_W +: PIX_W]       = PIX_W'(pix);
        in_dx[p*COORD_W +: COORD_W]    = COORD_W'(dx);
        in_dy[p*COORD_W +: COORD_W]    = COORD_W'(dy);
        in_frm[p*FRM_W +: FRM_W]       = FRM_W'(frm);
    endtask

    task automatic clear_in();
        in_vld = '0; in_pix = '0; in_dx = '0; in_dy = '0; in_frm = '0;
    endtask

    task automatic check_pkt(string tag, int o, int pix, int dx, int dy, int frm);
        check({tag, " valid"}, int'(out_vld[o]), 1);
        check({tag, " pixel"}, int'(out_pix[o*PIX_W +: PIX_W]), pix);
        check({tag, " dx"},    int'(out_dx[o*COORD_W +: COORD_W]), dx);
        check({tag, " dy"},    int'(out_dy[o*COORD_W +: COORD_W]), dy);
        check({tag, " frame"}, int'(out_frm[o*FRM_W +: FRM_W]), frm);
    endtask

    // Inputs are changed at a falling edge; the next rising edge latches them,
    // and the result is read at the falling edge after that.
    task automatic t_reset();
        @(negedge clk);
        check("R1 valid during reset", int'(out_vld), 0);
        check("R1 conflict during reset", int'(conflict), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after release", int'(out_vld), 0);
        check("R1 conflict after release", int'(conflict), 0);
    endtask

    task automatic t_single(string tag, int src, int dx, int dy, int pix, int frm);
        int d;
        d = dir_of(dx, dy);
        clear_in();
        put(src, pix, dx, dy, frm);
        @(negedge clk);
        clear_in();
        check_pkt({tag, " R7"}, d, pix, dx, dy, frm);
        check({tag, " only one output"}, $countones(out_vld), 1);
        check({tag, " R11 no conflict"}, int'(conflict), 0);
        @(negedge clk);
        check({tag, " R6 one-cycle pulse"}, int'(out_vld), 0);
    endtask

    task automatic t_ignored();
        clear_in();
        in_pix = '1; in_dx = '1; in_dy = '0; in_frm = '1;
        @(negedge clk);
        check("R10 invalid inputs ignored", int'(out_vld), 0);
        check("R10 no conflict", int'(conflict), 0);
        clear_in();
    endtask

    task automatic t_prio_local();
        clear_in();
        put(1, 8'h11, HX, HY, 1);
        put(0, 8'h22, HX, HY, 2);
        put(3, 8'h33, HX, HY, 3);
        @(negedge clk);
        clear_in();
        check_pkt("R8 north beats east and west", 4, 8'h22, HX, HY, 2);
        check("R9 conflict raised", int'(conflict), 1);
        check("R8 only winner out", $countones(out_vld), 1);
        @(negedge clk);
        check("R9 losers dropped", int'(out_vld), 0);
        check("R9 conflict one cycle", int'(conflict), 0);
    endtask

    task automatic t_prio_east();
        clear_in();
        put(4, 8'h44, 6, 0, 0);
        put(3, 8'h55, 5, 1, 1);
        put(2, 8'h66, 7, 3, 2);
        @(negedge clk);
        clear_in();
        check_pkt("R8 south beats west and local", 1, 8'h66, 7, 3, 2);
        check("R9 conflict on east", int'(conflict), 1);
        @(negedge clk);
        check("R9 east losers dropped", int'(out_vld), 0);
    endtask

    task automatic t_prio_all();
        clear_in();
        for (int p = 0; p < NP; p++) put(p, 8'h80 + p, 0, 5, p % 4);
        @(negedge clk);
        clear_in();
        check_pkt("R8 all five to west, north wins", 3, 8'h80, 0, 5, 0);
        check("R9 conflict five-way", int'(conflict), 1);
        @(negedge clk);
        check("R9 nothing after five-way", int'(out_vld), 0);
    endtask

    task automatic t_parallel();
        clear_in();
        put(0, 8'hA0, 2, 0, 0);
        put(1, 8'hA1, 0, 4, 1);
        put(2, 8'hA2, 2, 7, 2);
        put(3, 8'hA3, 5, 5, 3);
        put(4, 8'hA4, 2, 2, 1);
        @(negedge clk);
        clear_in();
        check("R11 all five out", int'(out_vld), 5'b11111);
        check("R11 no conflict", int'(conflict), 0);
        check_pkt("R4 south from north", 2, 8'hA0, 2, 0, 0);
        check_pkt("R3 west from east", 3, 8'hA1, 0, 4, 1);
        check_pkt("R4 north from south", 0, 8'hA2, 2, 7, 2);
        check_pkt("R2 east from west", 1, 8'hA3, 5, 5, 3);
        check_pkt("R5 local from local", 4, 8'hA4, 2, 2, 1);
    endtask

    task automatic t_back_to_back();
        clear_in();
        put(4, 8'h01, 7, 2, 1);
        @(negedge clk);
        clear_in();
        put(4, 8'h02, 3, 0, 2);
        check_pkt("R6 first of stream", 1, 8'h01, 7, 2, 1);
        @(negedge clk);
        clear_in();
        check_pkt("R6 second of stream", 1, 8'h02, 3, 0, 2);
        @(negedge clk);
        check("R6 stream ends", int'(out_vld), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_single("R2 east", 4, 5, 1, 8'h3C, 1);
        t_single("R3 west", 4, 0, 6, 8'hC3, 2);
        t_single("R4 north", 4, 2, 6, 8'h5A, 3);
        t_single("R4 south", 4, 2, 1, 8'hA5, 0);
        t_single("R5 local", 1, 2, 2, 8'hFF, 3);
        t_single("R2 east edge", 3, 3, 2, 8'h00, 0);
        t_single("R3 west edge", 1, 1, 2, 8'h7E, 1);
        t_ignored();
        t_prio_local();
        t_prio_east();
        t_prio_all();
        t_parallel();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule